// File: doc/BRIEF.md
# Data-Ready Slaved Conversion Sequencer

This block starts a successive-approximation conversion each time a free-running oversampling converter reports fresh data. That keeps the two converters sampling in step, so they do not drift apart over time. The data-ready line comes from an unrelated clock domain. A synchronizer chain resamples it onto the system clock, and only its rising edge is used. The cost is a start time that can vary by up to one system clock period.

Each accepted trigger runs a fixed sequence:
- an optional setup phase of programmable length, for input selection, gain change or settling;
- a convert strobe of programmable width;
- a transfer phase that waits for the read-out logic to hand back the result word.

The result is then presented with a one-cycle valid strobe. A trigger that arrives while the sequence is still running is dropped and reported as an overrun. A mode input can replace the data-ready source with a synchronous software trigger.

Top module: `conv_seq`

## Requirements
- R1: In data-ready mode (`sw_mode_i`=0), a rising edge of `drdy_i` starts a sequence. Count as edge 1 the first rising clock edge that samples `drdy_i` high. `conv_o` is then first seen high after edge 3+S, where S is `setup_cycles_i`.
- R2: Only a low-to-high transition of the resynchronized `drdy_i` counts as a trigger. Holding `drdy_i` high starts exactly one sequence.
- R3: `setup_o` is high for exactly S consecutive cycles, directly before `conv_o` rises. When S=0, `setup_o` never goes high.
- R4: Each accepted trigger gives exactly one `conv_o` pulse. The pulse lasts W cycles, where W is `conv_width_i`. A value of 0 is treated as 1.
- R5: In the cycle after `conv_o` falls, `rd_req_o` is high. It stays high until a cycle in which `rd_ack_i` is high. After that edge, `sample_valid_o` is high for one cycle, `sample_data_o` equals the `rd_data_i` sampled at that edge, and the block is idle again.
- R6: A trigger that arrives while `busy_o` is high does not start or restart a sequence. `overrun_o` is high for one cycle, in the cycle after that trigger.
- R7: With `sw_mode_i`=1, a one-cycle `sw_trig_i` high starts a sequence. `conv_o` is then first seen high after edge S+1, where edge 1 is the edge that samples `sw_trig_i` high. In this mode `drdy_i` has no effect. With `sw_mode_i`=0, `sw_trig_i` has no effect.
- R8: While `rst_ni` is low, `conv_o`, `setup_o`, `rd_req_o`, `sample_valid_o`, `overrun_o` and `busy_o` are all low.
- R9: At most one of `setup_o`, `conv_o` and `rd_req_o` is high in any cycle. `busy_o` is high exactly while one of the three phases is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| drdy_i | input | 1 | Data-ready line from the oversampling converter; asynchronous |
| sw_mode_i | input | 1 | 1 selects the software trigger, 0 selects data-ready |
| sw_trig_i | input | 1 | Synchronous software trigger; each high cycle is one trigger |
| setup_cycles_i | input | SETUP_W | Setup phase length in cycles, 0 skips the setup phase |
| conv_width_i | input | PW_W | Convert pulse width in cycles, 0 behaves as 1 |
| setup_o | output | 1 | Setup phase active |
| conv_o | output | 1 | Convert strobe to the converter |
| rd_req_o | output | 1 | Transfer phase: request for the result word |
| rd_ack_i | input | 1 | Result word present on rd_data_i |
| rd_data_i | input | DATA_W | Result word from the read-out logic |
| sample_valid_o | output | 1 | One-cycle strobe marking a captured result |
| sample_data_o | output | DATA_W | Captured result word |
| overrun_o | output | 1 | One-cycle flag for a trigger dropped while busy |
| busy_o | output | 1 | A sequence is in progress |

## Verification
A vector table exercises the sequence in both trigger modes. The vectors use setup lengths of zero, one and several cycles, and convert widths of zero, one and several cycles, so that the start latency, setup count and pulse width are each checked apart from the others. After every vector, data-ready stays high for extra cycles. This separates edge detection from level detection. Directed tests follow. One sends a second edge during the transfer phase, to tell an overrun apart from a restart. Others drive the unselected trigger source in each mode and confirm that it has no effect.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_CONV  = 2'd2,
    ST_READ  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/conv_seq_sync.sv
module conv_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= async_i;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int SETUP_W = 8,
  parameter int PW_W    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_i,
  input  logic [SETUP_W-1:0] setup_cycles_i,
  input  logic [PW_W-1:0]    conv_width_i,
  input  logic               rd_ack_i,
  output seq_state_e         state_o,
  output logic               overrun_o,
  output logic               capture_o
);
  localparam int CNT_W = (SETUP_W > PW_W) ? SETUP_W : PW_W;

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] width_m1;
  logic [CNT_W-1:0] setup_m1;

  // zero width behaves as one cycle
  assign width_m1 = (conv_width_i == '0) ? '0 : CNT_W'(conv_width_i) - CNT_W'(1);
  assign setup_m1 = CNT_W'(setup_cycles_i) - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      overrun_o <= 1'b0;
    end else begin
      overrun_o <= trig_i && (state_q != ST_IDLE);
      case (state_q)
        ST_IDLE: if (trig_i) begin
          if (setup_cycles_i != '0) begin
            state_q <= ST_SETUP;
            cnt_q   <= setup_m1;
          end else begin
            state_q <= ST_CONV;
            cnt_q   <= width_m1;
          end
        end
        ST_SETUP: if (cnt_q == '0) begin
          state_q <= ST_CONV;
          cnt_q   <= width_m1;
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_CONV: if (cnt_q == '0) state_q <= ST_READ;
                 else cnt_q <= cnt_q - CNT_W'(1);
        ST_READ: if (rd_ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = state_q;
  assign capture_o = (state_q == ST_READ) && rd_ack_i;
endmodule

// File: rtl/conv_seq_capture.sv
module conv_seq_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= capture_i;
      if (capture_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int SETUP_W     = 8,
  parameter int PW_W        = 4,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               drdy_i,
  input  logic               sw_mode_i,
  input  logic               sw_trig_i,
  input  logic [SETUP_W-1:0] setup_cycles_i,
  input  logic [PW_W-1:0]    conv_width_i,
  output logic               setup_o,
  output logic               conv_o,
  output logic               rd_req_o,
  input  logic               rd_ack_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               sample_valid_o,
  output logic [DATA_W-1:0]  sample_data_o,
  output logic               overrun_o,
  output logic               busy_o
);
  logic       drdy_rise;
  logic       trig;
  logic       capture;
  seq_state_e state;

  conv_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(drdy_i),
    .rise_o (drdy_rise)
  );

  assign trig = sw_mode_i ? sw_trig_i : drdy_rise;

  conv_seq_ctrl #(.SETUP_W(SETUP_W), .PW_W(PW_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .trig_i        (trig),
    .setup_cycles_i(setup_cycles_i),
    .conv_width_i  (conv_width_i),
    .rd_ack_i      (rd_ack_i),
    .state_o       (state),
    .overrun_o     (overrun_o),
    .capture_o     (capture)
  );

  conv_seq_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .data_i   (rd_data_i),
    .valid_o  (sample_valid_o),
    .data_o   (sample_data_o)
  );

  assign setup_o  = (state == ST_SETUP);
  assign conv_o   = (state == ST_CONV);
  assign rd_req_o = (state == ST_READ);
  assign busy_o   = (state != ST_IDLE);
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic setup_o,
  input logic conv_o,
  input logic rd_req_o,
  input logic rd_ack_i,
  input logic sample_valid_o,
  input logic overrun_o,
  input logic busy_o
);
  assert_phase_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({setup_o, conv_o, rd_req_o}) <= 1);

  assert_busy_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (setup_o || conv_o || rd_req_o));

  assert_conv_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_o) |-> $past(setup_o || !busy_o));

  assert_read_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(conv_o) |-> rd_req_o);

  assert_valid_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> $past(rd_req_o && rd_ack_i));

  assert_valid_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |=> !sample_valid_o);

  assert_overrun_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(busy_o));

  always_comb begin
    if (!rst_ni) assert_reset_idle_R8: assert (!busy_o);
  end
endmodule

bind conv_seq conv_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .setup_o       (setup_o),
  .conv_o        (conv_o),
  .rd_req_o      (rd_req_o),
  .rd_ack_i      (rd_ack_i),
  .sample_valid_o(sample_valid_o),
  .overrun_o     (overrun_o),
  .busy_o        (busy_o)
);

// File: tb/conv_seq_tb_top.sv
`timescale 1ns/1ps
module conv_seq_tb_top;
  localparam int SETUP_W = 8;
  localparam int PW_W    = 4;
  localparam int DATA_W  = 16;
  localparam int NVEC    = 6;
  // mode, setup, width, data
  localparam int VEC [NVEC][4] = '{
    '{0, 0, 1, 16'h1234},
    '{0, 3, 2, 16'hA5A5},
    '{0, 1, 0, 16'h0F0F},
    '{1, 0, 3, 16'h8001},
    '{1, 4, 1, 16'hFFFF},
    '{0, 2, 5, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drdy = 1'b0, sw_mode = 1'b0, sw_trig = 1'b0, rd_ack = 1'b0;
  logic [SETUP_W-1:0] setup_cycles = '0;
  logic [PW_W-1:0]    conv_width = '0;
  logic [DATA_W-1:0]  rd_data = '0;
  logic setup_o, conv_o, rd_req_o, sample_valid_o, overrun_o, busy_o;
  logic [DATA_W-1:0] sample_data_o;

  int tests = 0, fails = 0, cycles = 0;
  int conv_rises = 0, ovr_cnt = 0;
  logic conv_q = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  conv_seq #(.SETUP_W(SETUP_W), .PW_W(PW_W), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .drdy_i(drdy), .sw_mode_i(sw_mode),
    .sw_trig_i(sw_trig), .setup_cycles_i(setup_cycles), .conv_width_i(conv_width),
    .setup_o(setup_o), .conv_o(conv_o), .rd_req_o(rd_req_o), .rd_ack_i(rd_ack),
    .rd_data_i(rd_data), .sample_valid_o(sample_valid_o), .sample_data_o(sample_data_o),
    .overrun_o(overrun_o), .busy_o(busy_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    conv_q <= conv_o;
    if (conv_o && !conv_q) conv_rises <= conv_rises + 1;
    if (overrun_o) ovr_cnt <= ovr_cnt + 1;
    if (cycles > 50000 && !done) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: run did not complete, actual %0d cycles expected <= 50000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic run_one(input int mode, input int s, input int w, input int data);
    int n = 0, sc = 0, wc = 0, rises0;
    rises0 = conv_rises;
    sw_mode = mode[0];
    setup_cycles = SETUP_W'(s);
    conv_width = PW_W'(w);
    if (mode != 0) sw_trig = 1'b1; else drdy = 1'b1;
    while (!conv_o && n < 100) begin
      step(1);
      n++;
      sw_trig = 1'b0;
      if (setup_o) sc++;
    end
    if (mode != 0) check(n == s + 1, "R7 sw latency", n, s + 1);
    else check(n == s + 3, "R1 drdy latency", n, s + 3);
    check(sc == s, "R3 setup cycles", sc, s);
    while (conv_o && wc < 100) begin
      wc++;
      step(1);
    end
    check(wc == ((w == 0) ? 1 : w), "R4 conv width", wc, (w == 0) ? 1 : w);
    check(rd_req_o == 1'b1, "R5 request after conv", int'(rd_req_o), 1);
    step(2);
    check(rd_req_o == 1'b1 && !sample_valid_o, "R5 request held", int'(rd_req_o), 1);
    rd_ack = 1'b1;
    rd_data = DATA_W'(data);
    step(1);
    rd_ack = 1'b0;
    rd_data = '0;
    check(sample_valid_o && sample_data_o == DATA_W'(data), "R5 captured word",
          int'(sample_data_o), data);
    check(!busy_o, "R5 idle after ack", int'(busy_o), 0);
    step(1);
    check(!sample_valid_o, "R5 valid one cycle", int'(sample_valid_o), 0);
    step(6);
    check(conv_rises - rises0 == 1, "R2 one pulse per trigger", conv_rises - rises0, 1);
    drdy = 1'b0;
    step(4);
  endtask

  initial begin
    int r0;
    @(negedge clk);
    drdy = 1'b1;
    @(negedge clk);
    check(!conv_o && !setup_o && !rd_req_o && !sample_valid_o && !overrun_o && !busy_o,
          "R8 reset outputs", int'({conv_o, setup_o, rd_req_o, sample_valid_o, overrun_o, busy_o}), 0);
    drdy = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(2);

    for (int v = 0; v < NVEC; v++) run_one(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

    // R6: second edge during the transfer phase
    r0 = ovr_cnt;
    sw_mode = 1'b0;
    setup_cycles = 3;
    conv_width = 2;
    drdy = 1'b1;
    step(4);
    drdy = 1'b0;
    step(2);
    drdy = 1'b1;
    while (!rd_req_o) step(1);
    step(5);
    check(ovr_cnt - r0 == 1, "R6 overrun pulse count", ovr_cnt - r0, 1);
    check(rd_req_o && !conv_o && !setup_o, "R6 no restart", int'(rd_req_o), 1);
    r0 = conv_rises;
    rd_ack = 1'b1;
    rd_data = 16'h5A5A;
    step(1);
    rd_ack = 1'b0;
    check(sample_data_o == 16'h5A5A, "R6 capture after overrun", int'(sample_data_o), 16'h5A5A);
    step(8);
    check(conv_rises == r0 && !busy_o, "R6 dropped trigger not replayed", conv_rises - r0, 0);
    drdy = 1'b0;
    step(4);

    // R7: sw_trig ignored in data-ready mode
    r0 = conv_rises;
    sw_trig = 1'b1;
    step(1);
    sw_trig = 1'b0;
    step(8);
    check(conv_rises == r0 && !busy_o, "R7 sw_trig ignored", conv_rises - r0, 0);

    // R7: drdy ignored in software mode
    sw_mode = 1'b1;
    drdy = 1'b1;
    step(4);
    drdy = 1'b0;
    step(3);
    drdy = 1'b1;
    step(8);
    check(conv_rises == r0 && !busy_o, "R7 drdy ignored", conv_rises - r0, 0);
    drdy = 1'b0;
    step(2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule